// File: doc/BRIEF.md
# Shared Interrupt Enable and Routing Register Block

This block is the distributor-side register file for shared peripheral interrupts. Each shared line has an enable bit and a per-line routing word. Software changes an enable through one of two register arrays: writing a 1 to a bit in the set array turns that enable on, and writing a 1 to the same bit in the clear array turns it off. Each routing word is a single 64-bit register that holds four affinity bytes and a delivery-mode bit. A control register holds the group enables and the affinity-routing switch. It also carries a read-only flag that stays high for a fixed number of cycles after any configuration write, so software can poll until the change has taken effect.

Incoming lines are gated by their enable bit and by the group 1 enable. Among the lines that pass, the highest-numbered one is presented to the CPU-interface side together with its stored affinity and mode bit. Shared lines use IDs 32 and up. Line `irq_in[i]` carries ID 32+i. Two read-only registers report the number of lines the block covers and the architecture revision.

Writes use a 16-bit byte address and a 64-bit data word. The enable and control registers take the low 32 bits of the data. Reads are combinational from `rd_addr`.

Top module: `irq_dist_regs`

## Requirements
- R1: The control register at 0x0000 resets to 0. Bit 0 (group 1 enable), bit 1 (group 1 affinity-routed enable) and bit 4 (affinity routing enable) are written from the data and read back. All other bits ignore writes and read as 0, except bit 31.
- R2: Bit 31 of the control register is the write-pending flag. It reads 1 for exactly PEND_CYCLES (default 4) cycles following the clock edge that accepts a write to the control register, to an implemented enable word, or to an implemented routing entry. It then reads 0. A new such write restarts the full count.
- R3: The set-enable array starts at 0x0100 with a 4-byte stride. ID n maps to word n/32, bit n%32. Writing 1 to a bit sets that enable, and writing 0 leaves it unchanged. A read returns the current enable bits.
- R4: The clear-enable array starts at 0x0180 with the same word and bit mapping. Writing 1 to a bit clears that enable, and writing 0 leaves it unchanged. A read returns the same enable bits as the set array.
- R5: The routing entry for ID n is at 0x6000 + 8n and is written and read as 64 bits. Bits 7:0, 15:8, 23:16 and 39:32 store affinity levels 0, 1, 2 and 3. Bit 31 stores the mode: 0 delivers to the named target, 1 delivers to any CPU. All other bits read as 0.
- R6: The following read as 0 and ignore writes: enable bits and routing entries for IDs below 32 or at and above 32+NUM_SPI, the type and identification registers, addresses that are not aligned, and unmapped addresses. None of these writes raises the write-pending flag.
- R7: The type register at 0x0004 reads as N in bits 4:0, where N is the smallest value for which (N+1)*32 covers IDs 0 to 31+NUM_SPI. The identification register at 0xFFE8 reads as 0x30, which places architecture revision 3 in bits 7:4.
- R8: `fwd_valid` is high in the same cycle that a line is high, its enable is set and control bit 0 is set. `fwd_id` is the highest such ID. `fwd_aff` is {level 3, level 2, level 1, level 0} from that ID's routing entry, and `fwd_any` is its mode bit.
- R9: While control bit 0 is 0, or while no enabled line is high, `fwd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 64 | Write data; 32-bit registers use bits 31:0 |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 64 | Combinational read data |
| irq_in | input | NUM_SPI | Shared interrupt lines; bit i is ID 32+i |
| fwd_valid | output | 1 | A qualified line is being presented |
| fwd_id | output | 10 | ID of the presented line |
| fwd_aff | output | 32 | Affinity levels 3..0 of the presented line |
| fwd_any | output | 1 | Mode bit of the presented line |

## Verification
The bench builds the block with NUM_SPI = 40 and PEND_CYCLES = 4. With 40 lines, the second enable word is only partly populated (IDs 64 to 71), the third word lies wholly outside the block, and routing ID 72 is the first entry that does not exist. These cases test the edge handling of the enable and routing address ranges. With a short pending window, the bench can issue writes both inside and after the window. This checks that the count restarts on a new write and that the flag falls on the exact cycle.

// File: rtl/dist_pkg.sv
package dist_pkg;

   localparam logic [15:0] OFF_CTRL  = 16'h0000;
   localparam logic [15:0] OFF_TYPE  = 16'h0004;
   localparam logic [15:0] OFF_IDENT = 16'hFFE8;
   localparam logic [8:0]  SETEN_HI  = 9'h002;   // 0x0100 >> 7
   localparam logic [8:0]  CLREN_HI  = 9'h003;   // 0x0180 >> 7
   localparam logic [2:0]  ROUTE_HI  = 3'b011;   // 0x6000 >> 13
   localparam int          FIRST_ID  = 32;
   localparam int          ID_W      = 10;
   localparam logic [3:0]  ARCH_REV  = 4'h3;

   typedef struct packed {
      logic       any;
      logic [7:0] a3;
      logic [7:0] a2;
      logic [7:0] a1;
      logic [7:0] a0;
   } route_t;

   function automatic route_t route_unpack(input logic [63:0] d);
      route_t r;
      r.any = d[31];
      r.a3  = d[39:32];
      r.a2  = d[23:16];
      r.a1  = d[15:8];
      r.a0  = d[7:0];
      return r;
   endfunction

   function automatic logic [63:0] route_pack(input route_t r);
      return {24'h0, r.a3, r.any, 7'h0, r.a2, r.a1, r.a0};
   endfunction

endpackage

// File: rtl/dist_wpend.sv
module dist_wpend #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (CYCLES >= 1) else $fatal(1, "dist_wpend: CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (kick)          cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   assert_pend_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> busy);
   assert_pend_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !$past(kick));

endmodule

// File: rtl/dist_enables.sv
module dist_enables #(
   parameter int NUM = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           set_we,
   input  logic           clr_we,
   input  logic [4:0]     wr_word,
   input  logic [31:0]    wr_bits,
   input  logic [4:0]     rd_word,
   output logic [31:0]    rd_bits,
   output logic [NUM-1:0] en
);
   for (genvar i = 0; i < NUM; i++) begin : g_line
      localparam int W = (i + dist_pkg::FIRST_ID) / 32;
      localparam int B = (i + dist_pkg::FIRST_ID) % 32;
      logic hit_set, hit_clr;
      assign hit_set = set_we && (wr_word == 5'(W)) && wr_bits[B];
      assign hit_clr = clr_we && (wr_word == 5'(W)) && wr_bits[B];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       en[i] <= 1'b0;
         else if (hit_set) en[i] <= 1'b1;
         else if (hit_clr) en[i] <= 1'b0;
      end

      assert_set_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (set_we && wr_word == 5'(W) && wr_bits[B]) |=> en[i]);
      assert_clr_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && !set_we && wr_word == 5'(W) && wr_bits[B]) |=> !en[i]);
      assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!(set_we || clr_we) || wr_word != 5'(W) || !wr_bits[B]) |=> $stable(en[i]));
   end

   always_comb begin
      rd_bits = '0;
      for (int b = 0; b < 32; b++) begin
         int idx;
         idx = 32 * int'(rd_word) + b - dist_pkg::FIRST_ID;
         if (rd_word != 5'd0 && idx >= 0 && idx < NUM) rd_bits[b] = en[idx];
      end
   end

endmodule

// File: rtl/dist_routes.sv
module dist_routes #(
   parameter int NUM = 64,
   localparam int IW = $clog2(NUM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IW-1:0]    widx,
   input  logic [63:0]      wdata,
   input  logic [IW-1:0]    ridx,
   output dist_pkg::route_t rroute,
   input  logic [IW-1:0]    sidx,
   output dist_pkg::route_t sroute
);
   import dist_pkg::*;

   route_t rt_q [NUM];
   route_t wr_val;

   assign wr_val = route_unpack(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) rt_q[i] <= '0;
      end else if (we) begin
         rt_q[widx] <= wr_val;
      end
   end

   assign rroute = (int'(ridx) < NUM) ? rt_q[ridx] : '0;
   assign sroute = (int'(sidx) < NUM) ? rt_q[sidx] : '0;

   assert_route_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rt_q[$past(widx)] == $past(wr_val));

endmodule

// File: rtl/dist_pick.sv
module dist_pick #(
   parameter int NUM = 64,
   localparam int IW = $clog2(NUM)
) (
   input  logic [NUM-1:0] lines,
   input  logic [NUM-1:0] en,
   input  logic           grp_on,
   output logic           valid,
   output logic [IW-1:0]  idx
);
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = 0; i < NUM; i++) begin
         if (lines[i] && en[i] && grp_on) begin
            valid = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
   parameter int NUM_SPI     = 64,
   parameter int PEND_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [15:0]        wr_addr,
   input  logic [63:0]        wr_data,
   input  logic [15:0]        rd_addr,
   output logic [63:0]        rd_data,
   input  logic [NUM_SPI-1:0] irq_in,
   output logic               fwd_valid,
   output logic [9:0]         fwd_id,
   output logic [31:0]        fwd_aff,
   output logic               fwd_any
);
   import dist_pkg::*;

   localparam int IW        = $clog2(NUM_SPI);
   localparam int LAST_WORD = (NUM_SPI + FIRST_ID - 1) / 32;
   localparam int TYPE_N    = LAST_WORD;
   localparam int END_ID    = FIRST_ID + NUM_SPI;

   initial begin
      assert (NUM_SPI >= 2 && NUM_SPI <= 1020 - FIRST_ID)
         else $fatal(1, "irq_dist_regs: NUM_SPI out of range");
   end

   // write decode
   logic           ctrl_we, set_we, clr_we, route_we, kick, wword_ok, wid_ok;
   logic [4:0]     wword;
   logic [ID_W-1:0] wid, wid_rel;

   assign wword    = wr_addr[6:2];
   assign wword_ok = (wword != 5'd0) && (wword <= 5'(LAST_WORD));
   assign wid      = wr_addr[12:3];
   assign wid_ok   = (wid >= ID_W'(FIRST_ID)) && (wid < ID_W'(END_ID));
   assign wid_rel  = wid - ID_W'(FIRST_ID);

   assign ctrl_we  = wr_en && (wr_addr == OFF_CTRL);
   assign set_we   = wr_en && (wr_addr[15:7] == SETEN_HI) && (wr_addr[1:0] == 2'b00) && wword_ok;
   assign clr_we   = wr_en && (wr_addr[15:7] == CLREN_HI) && (wr_addr[1:0] == 2'b00) && wword_ok;
   assign route_we = wr_en && (wr_addr[15:13] == ROUTE_HI) && (wr_addr[2:0] == 3'b000) && wid_ok;
   assign kick     = ctrl_we || set_we || clr_we || route_we;

   // control register
   logic g1_q, g1a_q, are_q, busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g1_q  <= 1'b0;
         g1a_q <= 1'b0;
         are_q <= 1'b0;
      end else if (ctrl_we) begin
         g1_q  <= wr_data[0];
         g1a_q <= wr_data[1];
         are_q <= wr_data[4];
      end
   end

   dist_wpend #(.CYCLES(PEND_CYCLES)) i_wpend (
      .clk  (clk),
      .rst_n(rst_n),
      .kick (kick),
      .busy (busy)
   );

   // enables
   logic [NUM_SPI-1:0] en;
   logic [31:0]        en_rd;

   dist_enables #(.NUM(NUM_SPI)) i_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we),
      .clr_we (clr_we),
      .wr_word(wword),
      .wr_bits(wr_data[31:0]),
      .rd_word(rd_addr[6:2]),
      .rd_bits(en_rd),
      .en     (en)
   );

   // routes and selection
   logic [ID_W-1:0] rid, rid_rel;
   logic            rid_ok;
   logic            pick_valid;
   logic [IW-1:0]   pick_idx;
   route_t          rd_route, sel_route;

   assign rid     = rd_addr[12:3];
   assign rid_ok  = (rid >= ID_W'(FIRST_ID)) && (rid < ID_W'(END_ID));
   assign rid_rel = rid - ID_W'(FIRST_ID);

   dist_routes #(.NUM(NUM_SPI)) i_rt (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (route_we),
      .widx  (wid_rel[IW-1:0]),
      .wdata (wr_data),
      .ridx  (rid_rel[IW-1:0]),
      .rroute(rd_route),
      .sidx  (pick_idx),
      .sroute(sel_route)
   );

   dist_pick #(.NUM(NUM_SPI)) i_pick (
      .lines (irq_in),
      .en    (en),
      .grp_on(g1_q),
      .valid (pick_valid),
      .idx   (pick_idx)
   );

   assign fwd_valid = pick_valid;
   assign fwd_id    = pick_valid ? (ID_W'(FIRST_ID) + ID_W'(pick_idx)) : '0;
   assign fwd_aff   = pick_valid ? {sel_route.a3, sel_route.a2, sel_route.a1, sel_route.a0} : '0;
   assign fwd_any   = pick_valid && sel_route.any;

   // read mux
   always_comb begin
      rd_data = '0;
      if (rd_addr == OFF_CTRL)
         rd_data = {32'h0, busy, 26'h0, are_q, 2'b00, g1a_q, g1_q};
      else if (rd_addr == OFF_TYPE)
         rd_data = {59'h0, 5'(TYPE_N)};
      else if (rd_addr == OFF_IDENT)
         rd_data = {56'h0, ARCH_REV, 4'h0};
      else if ((rd_addr[15:7] == SETEN_HI || rd_addr[15:7] == CLREN_HI) && rd_addr[1:0] == 2'b00)
         rd_data = {32'h0, en_rd};
      else if (rd_addr[15:13] == ROUTE_HI && rd_addr[2:0] == 3'b000 && rid_ok)
         rd_data = route_pack(rd_route);
   end

   assert_grp_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !g1_q |-> !fwd_valid);
   assert_fwd_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (irq_in[pick_idx] && en[pick_idx]));
   assert_fwd_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fwd_id >= ID_W'(FIRST_ID) && fwd_id < ID_W'(END_ID)));
   assert_quiet_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !kick && !busy) |=> !busy);
   assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable({g1_q, g1a_q, are_q}));

endmodule

// File: tb/test_irq_dist_regs.sv
module test_irq_dist_regs;
   localparam int NUM  = 40;
   localparam int PEND = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [15:0]    wr_addr = '0;
   logic [63:0]    wr_data = '0;
   logic [15:0]    rd_addr = '0;
   logic [63:0]    rd_data;
   logic [NUM-1:0] irq_in = '0;
   logic           fwd_valid;
   logic [9:0]     fwd_id;
   logic [31:0]    fwd_aff;
   logic           fwd_any;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit run_chk = 1'b0;

   always #4 clk = ~clk;

   irq_dist_regs #(.NUM_SPI(NUM), .PEND_CYCLES(PEND)) i_irq_dist_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_in(irq_in),
      .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_aff(fwd_aff), .fwd_any(fwd_any)
   );

   // behavioural reference model
   bit          m_en [NUM];
   logic [63:0] m_rt [NUM];
   logic [31:0] m_ctrl;
   int          m_cnt;

   function automatic bit id_ok(int id);
      return id >= 32 && id < 32 + NUM;
   endfunction

   function automatic logic [63:0] m_read(logic [15:0] a);
      int w, id;
      logic [63:0] v;
      v = '0;
      if (a == 16'h0000) v = {32'h0, (m_cnt != 0), m_ctrl[30:0]};
      else if (a == 16'h0004) v = 64'((NUM + 31) / 32);
      else if (a == 16'hFFE8) v = 64'h30;
      else if (a >= 16'h0100 && a < 16'h0200 && a[1:0] == 0) begin
         w = int'(a[6:2]);
         for (int b = 0; b < 32; b++) begin
            id = 32 * w + b;
            if (id_ok(id)) v[b] = m_en[id - 32];
         end
      end else if (a >= 16'h6000 && a < 16'h8000 && a[2:0] == 0) begin
         id = int'(a[12:3]);
         if (id_ok(id)) v = m_rt[id - 32];
      end
      return v;
   endfunction

   function automatic string m_tag(logic [15:0] a);
      if (a == 16'h0000) return "R1/R2";
      if (a == 16'h0004 || a == 16'hFFE8) return "R7";
      if (a >= 16'h0100 && a < 16'h0180 && a[1:0] == 0 && a[6:2] >= 1 && a[6:2] <= 2) return "R3";
      if (a >= 16'h0180 && a < 16'h0200 && a[1:0] == 0 && a[6:2] >= 1 && a[6:2] <= 2) return "R4";
      if (a >= 16'h6000 && a < 16'h8000 && a[2:0] == 0 && id_ok(int'(a[12:3]))) return "R5";
      return "R6";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) begin m_en[i] = 0; m_rt[i] = '0; end
         m_ctrl = '0;
         m_cnt  = 0;
      end else begin
         bit kick;
         int w, id;
         kick = 0;
         if (wr_en) begin
            if (wr_addr == 16'h0000) begin
               m_ctrl = wr_data[31:0] & 32'h13;
               kick = 1;
            end else if (wr_addr >= 16'h0100 && wr_addr < 16'h0200 && wr_addr[1:0] == 0) begin
               w = int'(wr_addr[6:2]);
               if (w >= 1 && w <= (NUM + 31) / 32) begin
                  kick = 1;
                  for (int b = 0; b < 32; b++) begin
                     id = 32 * w + b;
                     if (wr_data[b] && id_ok(id)) m_en[id - 32] = (wr_addr < 16'h0180);
                  end
               end
            end else if (wr_addr >= 16'h6000 && wr_addr < 16'h8000 && wr_addr[2:0] == 0) begin
               id = int'(wr_addr[12:3]);
               if (id_ok(id)) begin
                  m_rt[id - 32] = wr_data & 64'h0000_00FF_80FF_FFFF;
                  kick = 1;
               end
            end
         end
         if (kick) m_cnt = PEND;
         else if (m_cnt > 0) m_cnt--;
      end
   end

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
      if (run_chk && rst_n) begin
         bit v;
         int best;
         check(m_tag(rd_addr), "rd_data", rd_data, m_read(rd_addr));
         v = 0; best = 0;
         for (int i = 0; i < NUM; i++)
            if (irq_in[i] && m_en[i] && m_ctrl[0]) begin v = 1; best = i; end
         if (v) begin
            check("R8", "fwd", {fwd_valid, fwd_any, 12'(fwd_id), fwd_aff},
                  {1'b1, m_rt[best][31], 12'(best + 32),
                   m_rt[best][39:32], m_rt[best][23:16], m_rt[best][15:8], m_rt[best][7:0]});
         end else begin
            check("R9", "fwd_valid", 64'(fwd_valid), 64'h0);
         end
      end
   end

   task automatic wr(logic [15:0] a, logic [63:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_hold(logic [15:0] a, int n);
      @(negedge clk); #1;
      rd_addr = a;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      run_chk = 1'b1;
      // reset state: R1, R7
      rd_hold(16'h0000, 2);
      rd_hold(16'h0004, 2);
      rd_hold(16'hFFE8, 2);
      rd_hold(16'h0104, 1);
      rd_hold(16'h6100, 1);
      // R1 writable bits, R2 pending window
      rd_hold(16'h0000, 1);
      wr(16'h0000, 64'hFFFF_FFFF_FFFF_FFFF);
      repeat (6) @(negedge clk);
      // R2 restart while pending
      wr(16'h0000, 64'h1);
      repeat (1) @(negedge clk);
      wr(16'h0000, 64'h11);
      repeat (6) @(negedge clk);
      // R3 set, R4 read-back of set data
      wr(16'h0104, 64'h5);
      rd_hold(16'h0104, 2);
      wr(16'h0108, 64'hFFFF_FFFF);
      rd_hold(16'h0188, 2);
      rd_hold(16'h010C, 1);
      // R6 word 0 and misaligned writes ignored, no pending
      rd_hold(16'h0000, 1);
      wr(16'h0100, 64'hFFFF_FFFF);
      wr(16'h0102, 64'hFFFF_FFFF);
      wr(16'h0004, 64'h1F);
      wr(16'hFFE8, 64'hFF);
      repeat (2) @(negedge clk);
      rd_hold(16'h0100, 2);
      rd_hold(16'h0004, 1);
      // R4 clear, zero bits have no effect
      wr(16'h0188, 64'h0F);
      wr(16'h0184, 64'h1);
      rd_hold(16'h0108, 2);
      rd_hold(16'h0104, 2);
      // R5 routes
      wr(16'h6000 + 16'(8 * 34), 64'hFFFF_FFFF_FFFF_FFFF);
      wr(16'h6000 + 16'(8 * 70), 64'h0000_00AB_8012_3456);
      wr(16'h6000 + 16'(8 * 33), 64'h0000_0011_0022_3344);
      rd_hold(16'h6000 + 16'(8 * 34), 2);
      rd_hold(16'h6000 + 16'(8 * 70), 2);
      // R6 routes out of range
      rd_hold(16'h0000, 1);
      wr(16'h6000 + 16'(8 * 72), 64'hFFFF_FFFF_FFFF_FFFF);
      wr(16'h6000 + 16'(8 * 5), 64'hFFFF_FFFF_FFFF_FFFF);
      repeat (2) @(negedge clk);
      rd_hold(16'h6000 + 16'(8 * 72), 1);
      rd_hold(16'h6000 + 16'(8 * 5), 1);
      rd_hold(16'h0504, 1);
      // R8 forwarding: ID 34 and ID 70 high, control bit 0 set
      @(negedge clk); #1;
      irq_in = '0; irq_in[2] = 1'b1; irq_in[38] = 1'b1;
      repeat (3) @(negedge clk);
      #1 irq_in[38] = 1'b0;
      repeat (2) @(negedge clk);
      #1 irq_in[1] = 1'b1;  // ID 33 is not enabled
      repeat (2) @(negedge clk);
      #1 irq_in[2] = 1'b0;
      repeat (2) @(negedge clk);
      // R9 group 1 off
      #1 irq_in[2] = 1'b1; irq_in[38] = 1'b1;
      wr(16'h0000, 64'h12);
      repeat (3) @(negedge clk);
      wr(16'h0000, 64'h1);
      repeat (3) @(negedge clk);
      #1 irq_in = '0;
      repeat (3) @(negedge clk);
      run_chk = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule